// File: doc/BRIEF.md
# Funnel Shifter with Byte Lane Extract and Insert

This block is a 32-bit datapath unit for reordering and moving bytes inside a word. It has three data operations. A funnel extract takes a 32-bit window out of the concatenation of two operands. A byte extract pulls one selected byte of the first operand into the low byte of the result. A byte insert writes the low byte of the second operand into a selected lane of the first operand. A fourth opcode loads a small control register that holds the funnel count and the byte pointer together.

When both operands of a funnel extract are the same word, the extract is a rotate. Byte extract does not zero-fill: the upper three bytes of its result come from the second operand. This merge behaviour is what lets three back-to-back operations (a rotate, a byte extract and a byte insert) reverse the byte order of a word. A mode input selects how a pointer value maps to a lane. Each result is registered and appears one cycle after issue, together with a valid strobe. A new operation can be issued on every cycle.

Top module: `fsh_unit`

## Requirements
- R1: After reset, `res_valid` and `res_data` are 0. The funnel count and the byte pointer are 0, so a funnel extract returns `src_a` and a little-endian byte extract takes bits [7:0].
- R2: A funnel extract (`op_code` 0) returns the upper 32 bits of the 64-bit value {`src_a`,`src_b`} shifted left by the funnel count.
- R3: A funnel extract with `src_a` equal to `src_b` returns `src_a` rotated left by the funnel count.
- R4: A byte extract (`op_code` 1) returns the selected lane of `src_a` in bits [7:0]. Bits [31:8] of the result are bits [31:8] of `src_b`.
- R5: A byte insert (`op_code` 2) returns `src_a` with its selected lane replaced by `src_b[7:0]`. All other lanes are unchanged.
- R6: With `big_endian` = 0, pointer p selects bits [8p+7:8p]. With `big_endian` = 1, pointer p selects bits [8(3-p)+7:8(3-p)], so pointer 0 is the most significant byte.
- R7: A control load (`op_code` 3) sets the funnel count from `src_a[4:0]` and the pointer from `src_a[6:5]`. Higher bits are ignored. The new values apply from the very next operation.
- R8: A control load raises no `res_valid`, and `res_data` keeps its previous value.
- R9: Each data operation gives `res_valid` = 1 exactly one cycle after issue, with no gap for back-to-back issue. A cycle with `op_valid` low gives `res_valid` = 0 on the next cycle.
- R10: With count 24, pointer 1 and `big_endian` = 1, the sequence extract(x,x) = t, byte extract(t,t) = u, byte insert(u,t) turns bytes a,b,c,d (MSB first) into d,c,b,a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation issue strobe |
| op_code | input | 2 | 0 funnel extract, 1 byte extract, 2 byte insert, 3 control load |
| big_endian | input | 1 | Lane numbering mode for the byte pointer |
| src_a | input | 32 | First operand; source of the control value on a load |
| src_b | input | 32 | Second operand |
| res_valid | output | 1 | Result valid, one cycle after issue |
| res_data | output | 32 | Registered result |

## Verification
The hardest situation to reach from the ports is one where the control register and the data operations interact. A load has to be followed at once by an operation that depends on the new count or pointer, with no idle cycle in between. The load value also needs junk in its upper bits, so that it shows those bits are ignored. The vector table therefore issues loads in the middle of a back-to-back stream, and it chains the byte-reversal sequence so that each step's operands are the previous step's result. Directed steps then cover an idle cycle and a reset in the middle of a run, which must clear a non-zero count.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

    typedef enum logic [1:0] {
        OP_FUNNEL = 2'd0,
        OP_BEXT   = 2'd1,
        OP_BINS   = 2'd2,
        OP_LDCTL  = 2'd3
    } fsh_op_e;

endpackage

// File: rtl/fsh_funnel.sv
module fsh_funnel #(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] hi_word,
    input  logic [DATA_W-1:0] lo_word,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] window
);
    logic [2*DATA_W-1:0] joined;

    always_comb begin
        joined = {hi_word, lo_word} << count;
        window = joined[2*DATA_W-1:DATA_W];
    end
endmodule

// File: rtl/fsh_lane.sv
module fsh_lane #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES = DATA_W / BYTE_W,
    localparam int PTR_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] word_a,
    input  logic [DATA_W-1:0] word_b,
    input  logic [PTR_W-1:0]  ptr,
    input  logic              big_endian,
    output logic [DATA_W-1:0] ext_out,
    output logic [DATA_W-1:0] ins_out
);
    logic [PTR_W-1:0]  lane;
    logic [BYTE_W-1:0] picked [LANES];

    always_comb begin
        lane = big_endian ? PTR_W'(LANES - 1) - ptr : ptr;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign picked[g] = word_a[g*BYTE_W +: BYTE_W];
        assign ins_out[g*BYTE_W +: BYTE_W] =
            (lane == PTR_W'(g)) ? word_b[BYTE_W-1:0] : word_a[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        ext_out = {word_b[DATA_W-1:BYTE_W], picked[lane]};
    end
endmodule

// File: rtl/fsh_ctl.sv
module fsh_ctl #(
    parameter int CNT_W = 5,
    parameter int PTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W+PTR_W-1:0] value,
    output logic [CNT_W-1:0] count,
    output logic [PTR_W-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            ptr   <= '0;
        end else if (load) begin
            count <= value[CNT_W-1:0];
            ptr   <= value[CNT_W +: PTR_W];
        end
    end

    assert_ctl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(count) && $stable(ptr)));
endmodule

// File: rtl/fsh_unit.sv
module fsh_unit
    import fsh_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES = DATA_W / BYTE_W,
    localparam int CNT_W = $clog2(DATA_W),
    localparam int PTR_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic              big_endian,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data
);
    fsh_op_e           op;
    logic              ld;
    logic [CNT_W-1:0]  count;
    logic [PTR_W-1:0]  ptr;
    logic [DATA_W-1:0] funnel_out, ext_out, ins_out, next_res;

    assign op = fsh_op_e'(op_code);
    assign ld = op_valid && (op == OP_LDCTL);

    fsh_ctl #(.CNT_W(CNT_W), .PTR_W(PTR_W)) i_ctl (
        .clk(clk), .rst_n(rst_n), .load(ld),
        .value(src_a[CNT_W+PTR_W-1:0]), .count(count), .ptr(ptr)
    );

    fsh_funnel #(.DATA_W(DATA_W)) i_funnel (
        .hi_word(src_a), .lo_word(src_b), .count(count), .window(funnel_out)
    );

    fsh_lane #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_lane (
        .word_a(src_a), .word_b(src_b), .ptr(ptr), .big_endian(big_endian),
        .ext_out(ext_out), .ins_out(ins_out)
    );

    always_comb begin
        unique case (op)
            OP_FUNNEL: next_res = funnel_out;
            OP_BEXT:   next_res = ext_out;
            OP_BINS:   next_res = ins_out;
            default:   next_res = res_data;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= op_valid && !ld;
            if (op_valid && !ld) res_data <= next_res;
        end
    end

    assert_load_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (!res_valid && $stable(res_data)));
    assert_issue_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op != OP_LDCTL) |=> res_valid);
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid);
    assert_bext_merge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_BEXT) |=> (res_data[DATA_W-1:BYTE_W] == $past(src_b[DATA_W-1:BYTE_W])));
endmodule

// File: tb/test_fsh_unit.sv
module test_fsh_unit;
    import fsh_pkg::*;

    typedef struct packed {
        logic [1:0]  op;
        logic        be;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 32'h11223344, 32'h55667788, 32'h11223344, 4'd1}, // R1 count 0
        '{2'd1, 1'b0, 32'h11223344, 32'hAABBCCDD, 32'hAABBCC44, 4'd4}, // R4 ptr 0 LE
        '{2'd1, 1'b1, 32'h11223344, 32'hAABBCCDD, 32'hAABBCC11, 4'd6}, // R6 ptr 0 BE
        '{2'd3, 1'b0, 32'h00000008, 32'h0,        32'hAABBCC11, 4'd8}, // R8 load cnt 8
        '{2'd0, 1'b0, 32'h11223344, 32'h55667788, 32'h22334455, 4'd2}, // R2
        '{2'd0, 1'b0, 32'hA1B2C3D4, 32'hA1B2C3D4, 32'hB2C3D4A1, 4'd3}, // R3 rotate
        '{2'd3, 1'b0, 32'hFFFFFF44, 32'h0,        32'hB2C3D4A1, 4'd7}, // R7 ptr 2 cnt 4, junk high
        '{2'd0, 1'b0, 32'h12345678, 32'h9ABCDEF0, 32'h23456789, 4'd7}, // R7 new count at once
        '{2'd2, 1'b0, 32'h11223344, 32'h000000EE, 32'h11EE3344, 4'd5}, // R5 lane 2
        '{2'd2, 1'b1, 32'h11223344, 32'h000000EE, 32'h1122EE44, 4'd6}, // R6 BE ptr 2 -> lane 1
        '{2'd1, 1'b0, 32'h11223344, 32'h00000000, 32'h00000022, 4'd4}, // R4
        '{2'd3, 1'b1, 32'h00000038, 32'h0,        32'h00000022, 4'd8}, // R8 ptr 1 cnt 24
        '{2'd0, 1'b1, 32'hAABBCCDD, 32'hAABBCCDD, 32'hDDAABBCC, 4'd10}, // R10 step 1
        '{2'd1, 1'b1, 32'hDDAABBCC, 32'hDDAABBCC, 32'hDDAABBAA, 4'd10}, // R10 step 2
        '{2'd2, 1'b1, 32'hDDAABBAA, 32'hDDAABBCC, 32'hDDCCBBAA, 4'd10}, // R10 reversed
        '{2'd0, 1'b0, 32'h01020304, 32'h05060708, 32'h04050607, 4'd2}, // R2 count 24
        '{2'd3, 1'b0, 32'h00000000, 32'h0,        32'h04050607, 4'd8}, // R8
        '{2'd0, 1'b0, 32'hCAFEF00D, 32'h12345678, 32'hCAFEF00D, 4'd2}  // R2 count 0 again
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'd0;
    logic        big_endian = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        res_valid;
    logic [31:0] res_data;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    fsh_unit i_fsh_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .big_endian(big_endian), .src_a(src_a), .src_b(src_b),
        .res_valid(res_valid), .res_data(res_data)
    );

    task automatic check(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R9: watchdog expired, actual 0 expected 1");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check(res_valid == 1'b0 && res_data == 32'h0, 1, {res_valid, res_data[30:0]}, 32'h0);
        rst_n = 1'b1;
        // table walk, back to back issue
        for (int i = 0; i <= NV; i++) begin
            @(negedge clk);
            if (i > 0) begin
                if (VECS[i-1].op == 2'd3) begin
                    // R8: load silent, data held
                    check(res_valid == 1'b0, 8, {31'h0, res_valid}, 32'h0);
                    check(res_data == VECS[i-1].exp, 8, res_data, VECS[i-1].exp);
                end else begin
                    // R9: strobe one cycle after issue
                    check(res_valid == 1'b1, 9, {31'h0, res_valid}, 32'h1);
                    check(res_data == VECS[i-1].exp, int'(VECS[i-1].req), res_data, VECS[i-1].exp);
                end
            end
            if (i < NV) begin
                op_valid   = 1'b1;
                op_code    = VECS[i].op;
                big_endian = VECS[i].be;
                src_a      = VECS[i].a;
                src_b      = VECS[i].b;
            end else begin
                op_valid = 1'b0;
            end
        end
        // R9: idle cycle gives no strobe, data held
        @(negedge clk);
        check(res_valid == 1'b0, 9, {31'h0, res_valid}, 32'h0);
        check(res_data == 32'hCAFEF00D, 9, res_data, 32'hCAFEF00D);
        // set a nonzero count, then reset mid-run: R1 count cleared
        op_valid = 1'b1; op_code = 2'd3; src_a = 32'h0000002C;
        @(negedge clk);
        op_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(res_valid == 1'b0 && res_data == 32'h0, 1, res_data, 32'h0);
        rst_n = 1'b1;
        op_valid = 1'b1; op_code = 2'd0; big_endian = 1'b0;
        src_a = 32'h89ABCDEF; src_b = 32'h01234567;
        @(negedge clk);
        check(res_data == 32'h89ABCDEF, 1, res_data, 32'h89ABCDEF);
        // R1: pointer cleared, LE byte extract takes bits [7:0]
        op_code = 2'd1; src_b = 32'h00000000;
        @(negedge clk);
        check(res_data == 32'h000000EF, 1, res_data, 32'h000000EF);
        op_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule